// File: doc/BRIEF.md
# Micromirror Array Block Load and Reset Sequencer

This control-path block sequences the loading of a 16-block micromirror array and issues the reset-start pulses that flip the loaded blocks. It does not move pixel data. For each enabled block it raises a one-cycle load strobe that carries the block index, the segment number, the load type and the row count. It then waits for a load-done handshake from the downstream data path. When a reset group is complete, it raises a one-cycle reset-start with a 16-bit block mask and waits for a reset-done acknowledge before it continues.

A 3-bit mode register selects the behaviour:

| Code | Mode |
|------|------|
| 0 | global |
| 1 | quad |
| 2 | double |
| 3 | single |
| 4 | global clear |
| 5 | global set |
| 6 | global load2 |
| 7 | single slow |

The mode decides how blocks are grouped for reset, whether a load carries data, whether rows are halved, and whether each block is sent as four serial segments. Mode writes may arrive at any time. They take effect only when a frame starts, so a frame in progress never changes behaviour.

Top module: `blk_load_seq`

## Requirements
- R1: After reset, `busy`, `load_stb`, `cmd_valid`, `rst_start` and `cfg_err` are low, `rst_mask` is zero and `active_mode` is 0.
- R2: `active_mode` changes only at a frame start, and a mode write during a frame leaves the frame unaffected. A write in the same cycle as `frame_start` applies to that frame; otherwise the last written value applies.
- R3: Global mode (0) loads every enabled block in ascending index order. A single reset-start then follows after the last block, with a mask equal to the set of loaded blocks.
- R4: Quad mode (1) resets each aligned group of four blocks (0-3, 4-7, 8-11, 12-15) right after the group's last block has loaded. The mask covers exactly that group.
- R5: Double mode (2) resets each aligned pair (0-1 through 14-15) right after the pair has loaded. The mask covers exactly that pair.
- R6: Single mode (3) issues a reset-start with a one-hot mask right after each block has loaded.
- R7: `load_type` is 0 for a data load, 1 for a clear load (mode 4) and 2 for a set load (mode 5). Clear and set loads keep `cmd_valid` low, and their reset timing is that of global mode. `cmd_valid` goes high with `load_stb` only for data loads.
- R8: In load2 mode (6), `load2` is high and `cmd_rows` = min(`row_count`/2, 68). In all other modes `load2` is low and `cmd_rows` = `row_count`.
- R9: Slow mode (7) issues four loads per enabled block, with `load_seg` 3, 2, 1 and 0 in that order, each after the previous load-done. One reset-start with a one-hot mask follows. In every other mode `load_seg` is 0.
- R10: Disabled blocks get no load. A group with no loaded block gets no reset-start, so a frame with no enabled block produces no reset-start at all and returns to idle.
- R11: In quad or double mode, a group whose enable bits are mixed is skipped entirely and sets `cfg_err`, which stays high until reset.
- R12: `rst_start` lasts exactly one cycle. No further load or reset-start is issued until `rst_done` has been received.
- R13: After a load strobe, no further load or reset-start is issued until `load_done` has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_in | input | 3 | Mode value to write |
| frame_start | input | 1 | Start a frame (accepted when idle) |
| blk_en | input | 16 | Block enable bits, sampled at frame start |
| row_count | input | ROW_W | Enabled row count of the frame |
| load_done | input | 1 | Downstream finished the current load |
| rst_done | input | 1 | Reset of the issued mask has completed |
| load_stb | output | 1 | One-cycle load command |
| load_blk | output | 4 | Block index of the load |
| load_seg | output | 2 | Segment number of the load |
| load_type | output | 2 | 0 data, 1 clear, 2 set |
| cmd_valid | output | 1 | Data follows the load command |
| load2 | output | 1 | One line fills two rows |
| cmd_rows | output | ROW_W | Row count passed downstream |
| rst_start | output | 1 | One-cycle reset-start pulse |
| rst_mask | output | 16 | Blocks reset by this pulse |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Sticky mixed-group error |
| active_mode | output | 3 | Mode used by the current or last frame |

## Verification
Every cycle, the assertions check the following:
- `rst_start` is a single-cycle pulse with a non-empty mask.
- In quad, double, single and slow modes, the reset mask has exactly the group's population.
- Data-less loads never raise `cmd_valid`.
- Halved row counts never exceed 68.
- The segment field is zero outside slow mode.
- `cfg_err` never falls.
- The mode does not change inside a frame.

Only the bench's scenarios can show the rest. They cover the complete ordering of loads and resets for every mode over a set of enable patterns, including empty, sparse and mixed-group patterns. They also cover the exact mask contents, the hold-off until each handshake, the halving and capping of row counts, and the timing of mode writes relative to a frame start.

// File: rtl/blk_load_seq.sv
module blk_load_seq #(
  parameter int BLK_N  = 16,
  parameter int ROW_W  = 11,
  parameter int L2_MAX = 68
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr,
  input  logic [2:0]               mode_in,
  input  logic                     frame_start,
  input  logic [BLK_N-1:0]         blk_en,
  input  logic [ROW_W-1:0]         row_count,
  input  logic                     load_done,
  input  logic                     rst_done,
  output logic                     load_stb,
  output logic [$clog2(BLK_N)-1:0] load_blk,
  output logic [1:0]               load_seg,
  output logic [1:0]               load_type,
  output logic                     cmd_valid,
  output logic                     load2,
  output logic [ROW_W-1:0]         cmd_rows,
  output logic                     rst_start,
  output logic [BLK_N-1:0]         rst_mask,
  output logic                     busy,
  output logic                     cfg_err,
  output logic [2:0]               active_mode
);
  localparam int IDX_W = $clog2(BLK_N);
  localparam int NQ    = BLK_N / 4;
  localparam int ND    = BLK_N / 2;
  localparam logic [2:0] M_GLB = 3'd0, M_QUAD = 3'd1, M_DBL = 3'd2, M_SGL = 3'd3,
                         M_CLR = 3'd4, M_SET = 3'd5, M_L2 = 3'd6, M_SLOW = 3'd7;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_N - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_LOAD, S_WAIT, S_NEXT, S_RST, S_RWAIT} st_t;

  st_t              st;
  logic [2:0]       mode_q, mode_pend, start_mode;
  logic [BLK_N-1:0] en_q, en_clean, acc;
  logic [IDX_W-1:0] idx, low_mask;
  logic [1:0]       seg;
  logic             mixed, slow, grp_last;
  logic [ROW_W-1:0] half_rows;

  assign start_mode = mode_wr ? mode_in : mode_pend;
  assign slow       = (mode_q == M_SLOW);

  always_comb begin
    en_clean = blk_en;
    mixed    = 1'b0;
    if (start_mode == M_QUAD) begin
      for (int g = 0; g < NQ; g++)
        if (blk_en[4*g +: 4] != 4'h0 && blk_en[4*g +: 4] != 4'hF) begin
          en_clean[4*g +: 4] = 4'h0;
          mixed = 1'b1;
        end
    end else if (start_mode == M_DBL) begin
      for (int g = 0; g < ND; g++)
        if (blk_en[2*g +: 2] == 2'b01 || blk_en[2*g +: 2] == 2'b10) begin
          en_clean[2*g +: 2] = 2'b00;
          mixed = 1'b1;
        end
    end
  end

  always_comb begin
    case (mode_q)
      M_QUAD:         low_mask = IDX_W'(3);
      M_DBL:          low_mask = IDX_W'(1);
      M_SGL, M_SLOW:  low_mask = '0;
      default:        low_mask = '1;
    endcase
  end
  assign grp_last = ((idx & low_mask) == low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode_q    <= M_GLB;
      mode_pend <= M_GLB;
      en_q      <= '0;
      acc       <= '0;
      idx       <= '0;
      seg       <= '0;
      cfg_err   <= 1'b0;
    end else begin
      if (mode_wr) mode_pend <= mode_in;
      case (st)
        S_IDLE:
          if (frame_start) begin
            mode_q  <= start_mode;
            en_q    <= en_clean;
            cfg_err <= cfg_err | mixed;
            idx     <= '0;
            acc     <= '0;
            st      <= S_SCAN;
          end
        S_SCAN:
          if (en_q[idx]) begin
            seg <= slow ? 2'd3 : 2'd0;
            st  <= S_LOAD;
          end else begin
            st  <= S_NEXT;
          end
        S_LOAD:
          st <= S_WAIT;
        S_WAIT:
          if (load_done) begin
            if (slow && seg != 2'd0) begin
              seg <= seg - 2'd1;
              st  <= S_LOAD;
            end else begin
              acc[idx] <= 1'b1;
              st       <= S_NEXT;
            end
          end
        S_NEXT:
          if (grp_last && acc != '0) st <= S_RST;
          else if (idx == LAST)      st <= S_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_SCAN;
          end
        S_RST:
          st <= S_RWAIT;
        S_RWAIT:
          if (rst_done) begin
            acc <= '0;
            if (idx == LAST) st <= S_IDLE;
            else begin
              idx <= idx + 1'b1;
              st  <= S_SCAN;
            end
          end
        default:
          st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign active_mode = mode_q;
  assign load_stb    = (st == S_LOAD);
  assign load_blk    = idx;
  assign load_seg    = seg;
  assign load_type   = (mode_q == M_CLR) ? 2'd1 : (mode_q == M_SET) ? 2'd2 : 2'd0;
  assign cmd_valid   = load_stb && (mode_q != M_CLR) && (mode_q != M_SET);
  assign load2       = (mode_q == M_L2);
  assign half_rows   = row_count >> 1;
  assign cmd_rows    = !load2 ? row_count :
                       (half_rows > ROW_W'(L2_MAX)) ? ROW_W'(L2_MAX) : half_rows;
  assign rst_start   = (st == S_RST);
  assign rst_mask    = rst_start ? acc : '0;

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> !rst_start);
  assert_mask_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |-> rst_mask != '0);
  assert_quad_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_start && active_mode == M_QUAD) |-> $countones(rst_mask) == 4);
  assert_pair_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_start && active_mode == M_DBL) |-> $countones(rst_mask) == 2);
  assert_single_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_start && (active_mode == M_SGL || active_mode == M_SLOW)) |-> $onehot(rst_mask));
  assert_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_type != 2'd0) |-> !cmd_valid);
  assert_rows_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load2 |-> cmd_rows <= ROW_W'(L2_MAX));
  assert_seg_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && active_mode != M_SLOW) |-> load_seg == 2'd0);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active_mode));
endmodule

// File: tb/blk_load_seq_tb_top.sv
`timescale 1ns/1ps
module blk_load_seq_tb_top;
  localparam int ROW_W = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, mode_wr, frame_start, load_done, rst_done;
  logic [2:0]       mode_in;
  logic [15:0]      blk_en;
  logic [ROW_W-1:0] row_count;
  logic             load_stb, cmd_valid, load2, rst_start, busy, cfg_err;
  logic [3:0]       load_blk;
  logic [1:0]       load_seg, load_type;
  logic [ROW_W-1:0] cmd_rows;
  logic [15:0]      rst_mask;
  logic [2:0]       active_mode;

  blk_load_seq #(.BLK_N(16), .ROW_W(ROW_W), .L2_MAX(68)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .frame_start(frame_start), .blk_en(blk_en), .row_count(row_count),
    .load_done(load_done), .rst_done(rst_done), .load_stb(load_stb),
    .load_blk(load_blk), .load_seg(load_seg), .load_type(load_type),
    .cmd_valid(cmd_valid), .load2(load2), .cmd_rows(cmd_rows),
    .rst_start(rst_start), .rst_mask(rst_mask), .busy(busy),
    .cfg_err(cfg_err), .active_mode(active_mode));

  int tests = 0, fails = 0;
  logic [31:0] got [128];
  logic [31:0] expv [128];
  int got_n, exp_n, viol_ld, viol_rd, rows_bad;
  logic [ROW_W-1:0] exp_rows;
  bit err_sticky;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expd);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
    end
  endtask

  // Handshake responder and event logger
  initial begin
    int ld_cnt, rd_cnt;
    ld_cnt = 0; rd_cnt = 0;
    load_done = 1'b0; rst_done = 1'b0;
    forever begin
      @(negedge clk);
      load_done = 1'b0;
      rst_done  = 1'b0;
      if (!rst_n) begin
        ld_cnt = 0; rd_cnt = 0;
      end else begin
        if (ld_cnt > 0) begin ld_cnt--; if (ld_cnt == 0) load_done = 1'b1; end
        if (rd_cnt > 0) begin rd_cnt--; if (rd_cnt == 0) rst_done = 1'b1; end
        if (load_stb) begin
          if (ld_cnt != 0) viol_ld++;
          if (rd_cnt != 0) viol_rd++;
          if (cmd_rows != exp_rows) rows_bad++;
          if (got_n < 128) got[got_n] = {22'd0, load2, cmd_valid, load_type, load_seg, load_blk};
          got_n++;
          ld_cnt = 2 + got_n % 3;
        end
        if (rst_start) begin
          if (ld_cnt != 0) viol_ld++;
          if (rd_cnt != 0) viol_rd++;
          if (got_n < 128) got[got_n] = {1'b1, 15'd0, rst_mask};
          got_n++;
          rd_cnt = 2 + got_n % 2;
        end
      end
    end
  end

  // Expected event list computed from the requirements
  task automatic build_exp(input logic [2:0] m, input logic [15:0] en_in);
    int gsz, nseg;
    logic [1:0] ty;
    logic cv, l2;
    logic [15:0] en, acc;
    en = en_in; exp_n = 0; acc = '0;
    gsz = (m == 3'd1) ? 4 : (m == 3'd2) ? 2 : (m == 3'd3 || m == 3'd7) ? 1 : 16;
    ty  = (m == 3'd4) ? 2'd1 : (m == 3'd5) ? 2'd2 : 2'd0;
    cv  = (ty == 2'd0);
    l2  = (m == 3'd6);
    nseg = (m == 3'd7) ? 4 : 1;
    if (gsz == 4 || gsz == 2)
      for (int g = 0; g < 16; g += gsz) begin
        int c;
        c = 0;
        for (int k = 0; k < gsz; k++) c += en[g+k];
        if (c != 0 && c != gsz) begin
          for (int k = 0; k < gsz; k++) en[g+k] = 1'b0;
          err_sticky = 1'b1;
        end
      end
    for (int b = 0; b < 16; b++) begin
      if (en[b]) begin
        for (int s = nseg - 1; s >= 0; s--) begin
          expv[exp_n] = {22'd0, l2, cv, ty, 2'(s), 4'(b)};
          exp_n++;
        end
        acc[b] = 1'b1;
      end
      if ((b % gsz) == gsz - 1 && acc != '0) begin
        expv[exp_n] = {1'b1, 15'd0, acc};
        exp_n++;
        acc = '0;
      end
    end
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic [15:0] en);
    if (en == 16'h0) return "R10";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic start_frame(input logic [2:0] m, input logic [15:0] en, input int rows,
                             input bit wr, input logic [2:0] em);
    build_exp(em, en);
    exp_rows = (em == 3'd6) ? ((rows / 2 > 68) ? ROW_W'(68) : ROW_W'(rows / 2)) : ROW_W'(rows);
    got_n = 0; viol_ld = 0; viol_rd = 0; rows_bad = 0;
    @(negedge clk);
    if (wr) begin mode_wr = 1'b1; mode_in = m; end
    blk_en = en; row_count = ROW_W'(rows); frame_start = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic finish_frame(input string tag, input logic [2:0] em);
    int mism, fa, fe;
    while (busy) @(negedge clk);
    chk(got_n == exp_n, tag, "event count", got_n, exp_n);
    mism = 0; fa = 0; fe = 0;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] !== expv[i]) begin
        if (mism == 0) begin fa = int'(got[i]); fe = int'(expv[i]); end
        mism++;
      end
    chk(mism == 0, tag, "event sequence", fa, fe);
    chk(viol_ld == 0, "R13", "issue before load_done", viol_ld, 0);
    chk(viol_rd == 0, "R12", "issue before rst_done", viol_rd, 0);
    chk(rows_bad == 0, "R8", "cmd_rows mismatches", rows_bad, 0);
    chk(cfg_err == err_sticky, "R11", "cfg_err", int'(cfg_err), int'(err_sticky));
    chk(active_mode == em, "R2", "active_mode", int'(active_mode), int'(em));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    err_sticky = 1'b0;
    @(negedge clk);
    chk(!busy && !load_stb && !cmd_valid && !rst_start, "R1", "idle outputs", 0, 0);
    chk(rst_mask == 16'h0 && !cfg_err, "R1", "mask/cfg_err", int'(rst_mask), 0);
    chk(active_mode == 3'd0, "R1", "active_mode", int'(active_mode), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] pats [8];
    int rows_l [8];
    pats = '{16'hFFFF, 16'h0000, 16'h00F0, 16'h0F0C, 16'hA5C3, 16'h8001, 16'h3CF0, 16'hFF00};
    rows_l = '{200, 50, 137, 1, 1024, 135, 136, 77};
    rst_n = 1'b0; mode_wr = 1'b0; mode_in = 3'd0; frame_start = 1'b0;
    blk_en = '0; row_count = '0;
    do_reset();

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++) begin
        start_frame(3'(m), pats[p], rows_l[(m + p) % 8], 1'b1, 3'(m));
        finish_frame(tag_of(3'(m), pats[p]), 3'(m));
      end

    // R2: write during a frame takes effect only at the next frame start
    do_reset();
    start_frame(3'd0, 16'hFFFF, 90, 1'b1, 3'd0);
    repeat (20) @(negedge clk);
    mode_wr = 1'b1; mode_in = 3'd3;
    @(negedge clk);
    mode_wr = 1'b0;
    chk(active_mode == 3'd0, "R2", "mode mid-frame", int'(active_mode), 0);
    finish_frame("R2", 3'd0);
    start_frame(3'd0, 16'h0F0F, 90, 1'b0, 3'd3);
    finish_frame("R2", 3'd3);
    start_frame(3'd5, 16'h1234, 90, 1'b1, 3'd5);
    finish_frame("R2", 3'd5);

    // R11: sticky error survives a clean frame, cleared by reset
    start_frame(3'd1, 16'h00F1, 90, 1'b1, 3'd1);
    finish_frame("R11", 3'd1);
    start_frame(3'd0, 16'hFFFF, 90, 1'b1, 3'd0);
    finish_frame("R11", 3'd0);
    do_reset();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule